// File: doc/BRIEF.md
# Register-Mapped UART Receiver

This block is an asynchronous serial receiver that a host controls through four byte-wide registers. The host sets a bit-rate divisor, then turns on the port and continuous reception. The block watches the serial line and times each bit from a 16x oversampling tick. It assembles frames of eight data bits, or nine when the wide mode is on, and queues the finished words in a two-entry buffer. The host reads the words from that buffer one at a time.

A control/status register shows the framing error and the ninth bit of the oldest unread word. It also holds a sticky overrun flag. A separate register holds the interrupt enable, the synchronous-mode bit and the receive-complete flag. The interrupt output is the receive-complete flag gated by its enable. If the port is turned off, or both receive enables are cleared, the buffer is flushed and the receiver returns to idle.

Register map (addr): 0 = control/status, 1 = receive data (a read pops the oldest word), 2 = divisor, 3 = interrupt/mode.

Top module: `uart_rx_regs`

## Requirements
- R1: After reset, registers 0, 2 and 3 read 0x00, `irq` is low and no word is buffered.
- R2: With divisor D in register 2, each serial bit lasts 16*(D+1) clock cycles. A frame is a low start bit, then data bits LSB first, then a high stop bit. Its eight data bits are read at address 1.
- R3: Reception runs only while register 0 bit 7 (port enable) and bit 4 (continuous receive) are both 1 and register 3 bit 2 (synchronous mode) is 0. At any other time, activity on the line leaves no word.
- R4: When register 0 bit 6 (nine-bit mode) is 1, a ninth data bit follows the eight data bits. That bit reads in register 0 bit 0 while its word is the oldest unread one. In eight-bit mode, bit 0 reads 0.
- R5: Register 0 bit 2 reads 1 when the oldest unread word had a low stop bit, and 0 otherwise.
- R6: Register 3 bit 1 (receive complete) is 1 while at least one word is buffered, and it clears once a read empties the buffer. `irq` equals that bit ANDed with register 3 bit 0.
- R7: Up to two words are held. Each read of address 1 returns the oldest one and removes it.
- R8: A third word that completes with no read in between sets register 0 bit 1 (overrun), and that word is dropped. While overrun is set, every new word is dropped and the buffered words are kept. Writing register 0 with bit 1 = 0 clears overrun.
- R9: When register 0 bit 7 is 0, or bits 5 and 4 are both 0, the buffer and the overrun flag are cleared and the receiver idles. Register 0 bit 3 always reads 0.
- R10: A low pulse on the line shorter than half a bit period is rejected as a start bit and produces no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops data at address 1) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| rx | input | 1 | Serial input line, idle high |
| irq | output | 1 | Receive interrupt |

## Verification
Some properties are checked on every cycle by the assertions: the buffer occupancy bound, that overrun stays set until it is cleared, that no word enters the buffer while overrun is set, the pop accounting, the flush on disable, and that the receiver idles whenever reception is off. The bench scenarios are the only way to show the rest. They cover the bit timing at several divisors, the bit order and ninth-bit placement, the framing-error value per word, and the order in which buffered words come out. They also check glitch rejection, and that frames arriving while the port is off or in synchronous mode have no effect.

// File: rtl/uart_rx_regs.sv
`timescale 1ns/1ps
module uart_rx_regs #(
  parameter int DIV_W = 8,
  parameter int OSR   = 16,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  input  logic             rx,
  output logic             irq
);
  localparam int CW = $clog2(OSR);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int AW = $clog2(DEPTH);
  localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  logic [DIV_W-1:0] div_q, div_cnt;
  logic port_en, nine_en, single_en, cont_en, oerr, int_en, sync_mode;
  logic rx_s1, rx_s2, rx_s3;
  st_t  state;
  logic [CW-1:0] os_cnt;
  logic [3:0] bit_idx;
  logic [8:0] shreg;
  logic [1:0] votes;
  logic done, done_fe;

  logic [7:0] data_m [DEPTH];
  logic       b9_m   [DEPTH];
  logic       fe_m   [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [PW-1:0] cnt;

  wire run   = port_en && cont_en && !sync_mode;
  wire flush = !port_en || (!single_en && !cont_en);
  wire tick  = (div_cnt == div_q);
  wire maj   = ({1'b0, votes} + {2'b0, rx_s2}) >= 3'd2;
  wire full  = (cnt == PW'(DEPTH));
  wire empty = (cnt == '0);
  wire pop   = rd_en && addr == 2'd1 && !empty;
  wire push_ok = done && !oerr && (!full || pop);
  wire ovf_set = done && !oerr && !push_ok;
  wire ctrl_wr = wr_en && addr == 2'd0;
  wire flag  = !empty;

  assign irq = flag && int_en;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      div_q <= '0; port_en <= 1'b0; nine_en <= 1'b0; single_en <= 1'b0;
      cont_en <= 1'b0; int_en <= 1'b0; sync_mode <= 1'b0;
    end else if (wr_en) begin
      case (addr)
        2'd0: {port_en, nine_en, single_en, cont_en} <= wdata[7:4];
        2'd2: div_q <= wdata[DIV_W-1:0];
        2'd3: begin int_en <= wdata[0]; sync_mode <= wdata[2]; end
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) {rx_s1, rx_s2, rx_s3} <= 3'b111;
    else        {rx_s1, rx_s2, rx_s3} <= {rx, rx_s1, rx_s2};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      state <= S_IDLE; div_cnt <= '0; os_cnt <= '0; bit_idx <= '0;
      shreg <= '0; votes <= '0; done <= 1'b0; done_fe <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!run) begin
        state <= S_IDLE; div_cnt <= '0; os_cnt <= '0;
      end else if (state == S_IDLE) begin
        div_cnt <= '0; os_cnt <= '0;
        if (rx_s3 && !rx_s2) state <= S_START;
      end else begin
        div_cnt <= tick ? '0 : div_cnt + 1'b1;
        if (tick) begin
          os_cnt <= os_cnt + 1'b1;
          if (os_cnt == MID)            votes <= {1'b0, rx_s2};
          else if (os_cnt == MID + 1'b1) votes <= votes + {1'b0, rx_s2};
          case (state)
            S_START: begin
              if (os_cnt == MID && rx_s2) state <= S_IDLE;
              else if (os_cnt == LAST) begin
                state <= S_DATA; os_cnt <= '0; bit_idx <= '0;
              end
            end
            S_DATA: begin
              if (os_cnt == MID + 2'd2) shreg <= {maj, shreg[8:1]};
              if (os_cnt == LAST) begin
                os_cnt <= '0;
                if (bit_idx == (nine_en ? 4'd8 : 4'd7)) state <= S_STOP;
                else bit_idx <= bit_idx + 1'b1;
              end
            end
            S_STOP: begin
              if (os_cnt == MID + 2'd2) begin
                done <= 1'b1; done_fe <= !maj; state <= S_IDLE;
              end
            end
            default: state <= S_IDLE;
          endcase
        end
      end
    end

  always_ff @(posedge clk)
    if (push_ok) begin
      data_m[wr_ptr] <= nine_en ? shreg[7:0] : shreg[8:1];
      b9_m[wr_ptr]   <= nine_en && shreg[8];
      fe_m[wr_ptr]   <= done_fe;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_ptr <= '0; rd_ptr <= '0; cnt <= '0; oerr <= 1'b0;
    end else if (flush) begin
      wr_ptr <= '0; rd_ptr <= '0; cnt <= '0; oerr <= 1'b0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop)     rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      cnt <= cnt + PW'(push_ok) - PW'(pop);
      if (ctrl_wr && !wdata[1]) oerr <= 1'b0;
      else if (ovf_set)         oerr <= 1'b1;
    end

  always_comb
    case (addr)
      2'd0: rdata = {port_en, nine_en, single_en, cont_en, 1'b0,
                     flag && fe_m[rd_ptr], oerr, flag && b9_m[rd_ptr]};
      2'd1: rdata = data_m[rd_ptr];
      2'd2: rdata = 8'(div_q);
      default: rdata = {5'b0, sync_mode, flag, int_en};
    endcase

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= PW'(DEPTH));
  p_ovr_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oerr && !flush && !(ctrl_wr && !wdata[1]) |=> oerr);
  p_ovr_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    oerr |=> cnt <= $past(cnt));
  p_idle_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> state == S_IDLE);
  p_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pop && !push_ok && !flush |=> cnt == $past(cnt) - 1'b1);
  p_flush_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty && !oerr);
endmodule

// File: tb/uart_rx_regs_bench.sv
`timescale 1ns/1ps
module uart_rx_regs_bench;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, rx = 1'b1;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic irq;
  int checks = 0, fails = 0, cycles = 0, div_cur = 0;
  bit finished = 0;

  uart_rx_regs u_uart_rx_regs (.clk, .rst_n, .wr_en, .rd_en, .addr, .wdata,
                               .rdata, .rx, .irq);

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000 && !finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  function automatic logic [7:0] exp_ctrl(bit p, bit n, bit s, bit c, bit fe, bit oe, bit b9);
    return {p, n, s, c, 1'b0, fe, oe, b9};
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    if (a == 2'd2) div_cur = d;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic line(logic v, int n);
    rx = v; repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [8:0] d, bit nine, bit stop_ok);
    int bc = 16 * (div_cur + 1);
    @(negedge clk);
    line(1'b0, bc);
    for (int i = 0; i < 8; i++) line(d[i], bc);
    if (nine) line(d[8], bc);
    line(stop_ok, bc);
    line(1'b1, 2 * bc);
  endtask

  logic [7:0] v;
  logic [8:0] words [2];
  bit fes [2];

  initial begin
    process::self().srandom(32'h5eed);
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rd(2'd0, v); chk("R1 ctrl", v, 8'h00);
    rd(2'd2, v); chk("R1 div", v, 8'h00);
    rd(2'd3, v); chk("R1 int", v, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    // R3: port off, frame ignored
    wr(2'd2, 8'd1);
    wr(2'd0, 8'h10);
    send(9'h0A5, 0, 1);
    rd(2'd3, v); chk("R3 port off", v, 8'h00);
    // R3: sync mode blocks
    wr(2'd3, 8'h04);
    wr(2'd0, 8'h90);
    send(9'h05A, 0, 1);
    rd(2'd3, v); chk("R3 sync mode", v, 8'h04);
    wr(2'd3, 8'h01);

    // R2 basic frame and R6 irq
    send(9'h0C3, 0, 1);
    rd(2'd3, v); chk("R6 flag set", v, 8'h03);
    chk("R6 irq on", {7'b0, irq}, 8'h01);
    wr(2'd3, 8'h00);
    chk("R6 irq gated", {7'b0, irq}, 8'h00);
    rd(2'd1, v); chk("R2 data", v, 8'hC3);
    rd(2'd3, v); chk("R6 flag clear", v, 8'h00);

    // R10 glitch
    @(negedge clk); line(1'b0, 3 * (div_cur + 1)); line(1'b1, 40 * (div_cur + 1));
    rd(2'd3, v); chk("R10 glitch", v, 8'h00);

    // R4 nine bit, R5 framing
    wr(2'd0, 8'hD0);
    send(9'h13C, 1, 0);
    rd(2'd0, v); chk("R4 R5 status", v, exp_ctrl(1,1,0,1,1,0,1));
    rd(2'd1, v); chk("R4 data", v, 8'h3C);

    // R7 R8 overrun
    wr(2'd0, 8'h90);
    send(9'h011, 0, 1); send(9'h022, 0, 1); send(9'h033, 0, 1);
    rd(2'd0, v); chk("R8 overrun set", v, exp_ctrl(1,0,0,1,0,1,0));
    send(9'h044, 0, 1);
    rd(2'd1, v); chk("R7 oldest", v, 8'h11);
    rd(2'd1, v); chk("R8 kept second", v, 8'h22);
    rd(2'd3, v); chk("R8 third dropped", v, 8'h00);
    wr(2'd0, 8'h90);
    rd(2'd0, v); chk("R8 cleared", v, exp_ctrl(1,0,0,1,0,0,0));
    send(9'h055, 0, 1);
    rd(2'd1, v); chk("R8 resumes", v, 8'h55);

    // R9 flush
    send(9'h066, 0, 1);
    wr(2'd0, 8'h00);
    rd(2'd3, v); chk("R9 flushed", v, 8'h00);
    wr(2'd0, 8'hA0);
    rd(2'd0, v); chk("R9 bit3 zero", v, exp_ctrl(1,0,1,0,0,0,0));

    // random
    for (int it = 0; it < 24; it++) begin
      bit nine = $urandom_range(0, 1);
      int n = $urandom_range(1, 2);
      wr(2'd2, 8'($urandom_range(0, 3)));
      wr(2'd0, {1'b1, nine, 2'b01, 4'b0});
      for (int k = 0; k < n; k++) begin
        words[k] = 9'($urandom);
        fes[k] = ($urandom_range(0, 3) == 0);
        send(words[k], nine, !fes[k]);
      end
      for (int k = 0; k < n; k++) begin
        rd(2'd0, v);
        chk("R4 R5 rand status", v, exp_ctrl(1, nine, 0, 1, fes[k], 0, nine & words[k][8]));
        rd(2'd1, v); chk("R2 R7 rand data", v, words[k][7:0]);
      end
      rd(2'd3, v); chk("R6 rand empty", v, 8'h00);
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule